// File: doc/BRIEF.md
# Backplane Serial Command Link

This block carries fixed-size command and message words between a central controller and its peripheral boards over a clocked serial link that has no handshake. A continuous shared clock times everything. A word is a 24-bit value: the top 8 bits name the destination board and the low 16 bits are the payload. Each bit lasts eight clock cycles. Between words the line rests low. A word opens with a single high start bit, sends its 24 bits most significant first, and closes with one low stop period.

On the controller side, the block serialises a parallel word onto the command line. It also deserialises whatever arrives on the telemetry line, at whatever rate the peripheral sends it. On the peripheral side, a second deserialiser watches the command line and keeps only words addressed to its own board. It queues their payloads in a small buffer, so that several commands sent one after another are all kept until the board logic reads them.

Top module: `bp_cmd_link`

## Requirements
- R1: After reset, cmdOut is low, txBusy is low, telValid is low, cmdAvail is low and cmdOverflow is low.
- R2: A txStart seen while idle starts a frame in the next cycle. The line is high for 8 cycles (start bit), then carries txWord bit 23 down to bit 0 for 8 cycles each, then is low for 8 cycles (stop). txBusy is high for exactly those 208 cycles, and cmdOut is low whenever txBusy is low.
- R3: A txStart raised while txBusy is high is ignored: no second word is sent and the frame under way is unchanged.
- R4: The telemetry receiver samples each bit at its fourth clock. It raises telValid for one cycle with telWord equal to the sent word (address in bits 23:16, data in 15:0), 196 cycles after the first high cycle of the start bit.
- R5: A high level on an idle receive line that lasts fewer than 4 cycles is discarded and produces no word.
- R6: The peripheral receiver stores a word only if its bits 23:16 equal myAddr. Other words leave cmdAvail and cmdData unchanged.
- R7: Stored payloads leave in arrival order. cmdData shows the oldest entry while cmdAvail is high, and a cmdPop removes it. Up to 4 words sent back to back are all kept.
- R8: A matching word that arrives while 4 entries are held (and no pop happens in that cycle) is dropped. The held entries are unchanged, and cmdOverflow goes high and stays high until reset.
- R9: A cmdPop while the buffer is empty has no effect, and later words are stored and read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous shared link clock |
| rstN | input | 1 | Active-low synchronous reset |
| txStart | input | 1 | Request to send txWord |
| txWord | input | 24 | Word to send: address 23:16, data 15:0 |
| txBusy | output | 1 | Frame in progress; new requests ignored |
| cmdOut | output | 1 | Serial command line driven by the controller |
| telIn | input | 1 | Serial telemetry line from the peripheral |
| telValid | output | 1 | One-cycle strobe: telWord holds a new word |
| telWord | output | 24 | Last word received on the telemetry line |
| cmdIn | input | 1 | Serial command line as seen by the peripheral |
| myAddr | input | 8 | Address this peripheral answers to |
| cmdPop | input | 1 | Remove the oldest buffered payload |
| cmdAvail | output | 1 | Buffer holds at least one payload |
| cmdData | output | 16 | Oldest buffered payload |
| cmdOverflow | output | 1 | Sticky flag: a matching word was dropped |

## Verification
The bench checks the serial frame cycle by cycle and the exact cycle in which a received word is flagged. A design with an off-by-one bit timer or a reversed bit order shows up as a framing or value mismatch. A start pulse shorter than half a bit is sent on its own, to catch a receiver that starts a word on any high level. Requests made mid-frame and words for a foreign address are sent, to catch a transmitter that restarts or a filter that lets everything through. The buffer is filled past its depth, and also popped while empty, to catch pointer wrap errors, lost or reordered back-to-back commands, and an overflow flag that never sets or clears by itself.

// File: rtl/bp_link_pkg.sv
package bp_link_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  typedef struct packed {
    logic clear;
    logic shift;
    logic last;
  } rxStrobe_t;
endpackage

// File: rtl/bp_link_tx.sv
module bp_link_tx #(
  parameter int CLKS_PER_BIT = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              lineOut
);
  localparam int FRAME_W = WORD_W + 2;
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IDX_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] frameSr;
  logic [CNT_W-1:0]   cyc;
  logic [IDX_W-1:0]   idx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      frameSr <= '0;
      cyc     <= '0;
      idx     <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        frameSr <= {1'b1, word, 1'b0};
        cyc     <= '0;
        idx     <= '0;
      end
    end else if (cyc == CNT_W'(CLKS_PER_BIT - 1)) begin
      cyc <= '0;
      if (idx == IDX_W'(FRAME_W - 1)) begin
        busy    <= 1'b0;
        frameSr <= '0;
      end else begin
        idx     <= idx + 1'b1;
        frameSr <= {frameSr[FRAME_W-2:0], 1'b0};
      end
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  assign lineOut = frameSr[FRAME_W-1];
endmodule

// File: rtl/bp_link_rx_ctrl.sv
module bp_link_rx_ctrl
  import bp_link_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int WORD_W = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lineIn,
  output rxStrobe_t strobe
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int HALF  = CLKS_PER_BIT / 2 - 1;

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic             bitEnd;

  assign bitEnd = (cnt == CNT_W'(CLKS_PER_BIT - 1));

  always_comb begin
    strobe.clear = (state == RX_START) && (cnt == CNT_W'(HALF)) && lineIn;
    strobe.shift = (state == RX_DATA) && bitEnd;
    strobe.last  = strobe.shift && (bitCnt == BIT_W'(WORD_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        RX_IDLE: if (lineIn) begin
          state <= RX_START;
          cnt   <= CNT_W'(1);
        end
        RX_START: if (cnt == CNT_W'(HALF)) begin
          state  <= lineIn ? RX_DATA : RX_IDLE;
          cnt    <= '0;
          bitCnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        RX_DATA: if (bitEnd) begin
          cnt <= '0;
          if (strobe.last) state <= RX_STOP;
          else bitCnt <= bitCnt + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: if (bitEnd) begin
          state <= RX_IDLE;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bp_link_rx_dp.sv
module bp_link_rx_dp
  import bp_link_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineIn,
  input  rxStrobe_t         strobe,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= strobe.last;
      if (strobe.shift) word <= {word[WORD_W-2:0], lineIn};
    end
  end
endmodule

// File: rtl/bp_link_fifo.sv
module bp_link_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic popOk, pushOk, isFull;

  assign isFull = (count == CNT_W'(DEPTH));
  assign popOk  = pop && (count != '0);
  assign pushOk = push && (!isFull || popOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pushOk) begin
        wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      end
      if (popOk) begin
        rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      if (push && !pushOk) overflow <= 1'b1;
      count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
    end
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  assign headData = mem[rdPtr];
  assign notEmpty = (count != '0);
endmodule

// File: rtl/bp_cmd_link.sv
module bp_cmd_link #(
  parameter int CLKS_PER_BIT = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     txStart,
  input  logic [ADDR_W+DATA_W-1:0] txWord,
  output logic                     txBusy,
  output logic                     cmdOut,
  input  logic                     telIn,
  output logic                     telValid,
  output logic [ADDR_W+DATA_W-1:0] telWord,
  input  logic                     cmdIn,
  input  logic [ADDR_W-1:0]        myAddr,
  input  logic                     cmdPop,
  output logic                     cmdAvail,
  output logic [DATA_W-1:0]        cmdData,
  output logic                     cmdOverflow
);
  import bp_link_pkg::*;
  localparam int WORD_W = ADDR_W + DATA_W;

  rxStrobe_t         telStrobe, cmdStrobe;
  logic              cmdRxValid;
  logic [WORD_W-1:0] cmdRxWord;
  logic              addrHit;

  bp_link_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rstN(rstN), .start(txStart), .word(txWord),
    .busy(txBusy), .lineOut(cmdOut)
  );

  bp_link_rx_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .WORD_W(WORD_W)) u_telCtrl (
    .clk(clk), .rstN(rstN), .lineIn(telIn), .strobe(telStrobe)
  );
  bp_link_rx_dp #(.WORD_W(WORD_W)) u_telDp (
    .clk(clk), .rstN(rstN), .lineIn(telIn), .strobe(telStrobe),
    .word(telWord), .valid(telValid)
  );

  bp_link_rx_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .WORD_W(WORD_W)) u_cmdCtrl (
    .clk(clk), .rstN(rstN), .lineIn(cmdIn), .strobe(cmdStrobe)
  );
  bp_link_rx_dp #(.WORD_W(WORD_W)) u_cmdDp (
    .clk(clk), .rstN(rstN), .lineIn(cmdIn), .strobe(cmdStrobe),
    .word(cmdRxWord), .valid(cmdRxValid)
  );

  assign addrHit = cmdRxValid && (cmdRxWord[WORD_W-1:DATA_W] == myAddr);

  bp_link_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .push(addrHit), .pushData(cmdRxWord[DATA_W-1:0]),
    .pop(cmdPop), .headData(cmdData), .notEmpty(cmdAvail), .overflow(cmdOverflow)
  );
endmodule

// File: rtl/bp_cmd_link_chk.sv
module bp_cmd_link_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     txBusy,
  input logic                     cmdOut,
  input logic                     telValid,
  input logic                     cmdRxValid,
  input logic [ADDR_W+DATA_W-1:0] cmdRxWord,
  input logic [ADDR_W-1:0]        myAddr,
  input logic                     cmdPop,
  input logic                     cmdAvail,
  input logic [DATA_W-1:0]        cmdData,
  input logic                     cmdOverflow
);
  localparam int WORD_W = ADDR_W + DATA_W;

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> !cmdOut); // R2
  AST_START_BIT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> cmdOut); // R2
  AST_TEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    telValid |=> !telValid); // R4
  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRxValid && (cmdRxWord[WORD_W-1:DATA_W] != myAddr) && !cmdPop)
      |=> ($stable(cmdAvail) && $stable(cmdData))); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    cmdOverflow |=> cmdOverflow); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdAvail && !cmdRxValid) |=> !cmdAvail); // R9
endmodule

bind bp_cmd_link bp_cmd_link_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .txBusy(txBusy), .cmdOut(cmdOut), .telValid(telValid),
  .cmdRxValid(cmdRxValid), .cmdRxWord(cmdRxWord), .myAddr(myAddr), .cmdPop(cmdPop),
  .cmdAvail(cmdAvail), .cmdData(cmdData), .cmdOverflow(cmdOverflow)
);

// File: tb/bp_cmd_link_bench.sv
module bp_cmd_link_bench;
  localparam logic [7:0] MY = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txStart = 1'b0;
  logic [23:0] txWord = '0;
  logic txBusy, cmdOut, telValid, cmdAvail, cmdOverflow;
  logic [23:0] telWord;
  logic [15:0] cmdData;
  logic cmdPop = 1'b0;
  logic telSel = 1'b1;
  logic telDrv = 1'b0;
  logic telIn;

  int nChecks = 0;
  int nFail = 0;
  int telCount = 0;
  bit running = 1'b0;
  logic [23:0] expTel [$];
  logic [15:0] expCmd [$];

  assign telIn = telSel ? cmdOut : telDrv;

  always #10 clk = ~clk;

  bp_cmd_link u_bp_cmd_link (
    .clk(clk), .rstN(rstN), .txStart(txStart), .txWord(txWord), .txBusy(txBusy),
    .cmdOut(cmdOut), .telIn(telIn), .telValid(telValid), .telWord(telWord),
    .cmdIn(cmdOut), .myAddr(MY), .cmdPop(cmdPop), .cmdAvail(cmdAvail),
    .cmdData(cmdData), .cmdOverflow(cmdOverflow)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // monitor side of the scoreboard: every telemetry word must be expected, in order
  always @(negedge clk) begin
    if (running && telValid) begin
      telCount++;
      if (expTel.size() == 0) chk("R4 unexpected telemetry word", {8'h0, telWord}, 32'hFFFFFFFF);
      else chk("R4 telemetry word", {8'h0, telWord}, {8'h0, expTel.pop_front()});
    end
  end

  task automatic expect_word(input logic [23:0] w);
    expTel.push_back(w);
    if (w[23:16] == MY && expCmd.size() < 4) expCmd.push_back(w[15:0]);
  endtask

  task automatic send_word(input logic [23:0] w);
    while (txBusy) @(negedge clk);
    expect_word(w);
    txWord = w;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
  endtask

  task automatic pop_check(input string req);
    logic [15:0] e;
    e = expCmd.pop_front();
    chk(req, {31'h0, cmdAvail}, 32'h1);
    chk(req, {16'h0, cmdData}, {16'h0, e});
    cmdPop = 1'b1;
    @(negedge clk);
    cmdPop = 1'b0;
    @(negedge clk);
  endtask

  task automatic bang_word(input logic [23:0] w);
    logic [25:0] fr;
    fr = {1'b1, w, 1'b0};
    for (int b = 25; b >= 0; b--) begin
      repeat (8) begin
        telDrv = fr[b];
        @(negedge clk);
      end
    end
    telDrv = 1'b0;
  endtask

  initial begin
    #4000000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [23:0] wA;
    logic [25:0] fr;
    int bitErr, busyErr, validAt, base;
    wA = {MY, 16'hBEEF};
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmdOut", {31'h0, cmdOut}, 0);
    chk("R1 txBusy", {31'h0, txBusy}, 0);
    chk("R1 telValid", {31'h0, telValid}, 0);
    chk("R1 cmdAvail", {31'h0, cmdAvail}, 0);
    chk("R1 cmdOverflow", {31'h0, cmdOverflow}, 0);

    // R2 frame shape, R3 mid-frame request, R4 flag timing
    expect_word(wA);
    fr = {1'b1, wA, 1'b0};
    txWord = wA;
    txStart = 1'b1;
    @(negedge clk);
    txStart = 1'b0;
    bitErr = 0; busyErr = 0; validAt = -1;
    for (int i = 0; i < 208; i++) begin
      if (cmdOut !== fr[25 - i / 8]) bitErr++;
      if (txBusy !== 1'b1) busyErr++;
      if (telValid && validAt < 0) validAt = i;
      if (i == 50) begin txStart = 1'b1; txWord = {MY, 16'h0BAD}; end
      if (i == 51) txStart = 1'b0;
      @(negedge clk);
    end
    chk("R2 frame bits", bitErr, 0);
    chk("R2 busy length", busyErr, 0);
    chk("R2 busy drops", {31'h0, txBusy}, 0);
    chk("R2 line idle", {31'h0, cmdOut}, 0);
    chk("R4 flag cycle", validAt, 196);
    repeat (250) @(negedge clk);
    chk("R3 single word sent", telCount, 1);
    chk("R3 line idle after", {31'h0, txBusy}, 0);

    // R6 foreign address
    send_word({8'h55, 16'h1234});
    repeat (220) @(negedge clk);
    chk("R6 avail", {31'h0, cmdAvail}, 1);
    chk("R6 head unchanged", {16'h0, cmdData}, 32'hBEEF);

    // R7 back-to-back words kept in order
    send_word({MY, 16'h1111});
    send_word({MY, 16'h2222});
    send_word({MY, 16'h3333});
    repeat (220) @(negedge clk);
    for (int k = 0; k < 4; k++) pop_check("R7 order");
    chk("R7 empty after", {31'h0, cmdAvail}, 0);

    // R9 pop on empty
    cmdPop = 1'b1;
    @(negedge clk);
    cmdPop = 1'b0;
    @(negedge clk);
    chk("R9 still empty", {31'h0, cmdAvail}, 0);
    send_word({MY, 16'h4444});
    repeat (220) @(negedge clk);
    pop_check("R9 pointers intact");
    chk("R9 empty again", {31'h0, cmdAvail}, 0);

    // R8 overflow
    for (int k = 0; k < 4; k++) send_word({MY, 16'hA000 + 16'(k)});
    repeat (220) @(negedge clk);
    chk("R8 no overflow at 4", {31'h0, cmdOverflow}, 0);
    send_word({MY, 16'hDEAD});
    send_word({MY, 16'hFACE});
    repeat (220) @(negedge clk);
    chk("R8 overflow set", {31'h0, cmdOverflow}, 1);
    for (int k = 0; k < 4; k++) pop_check("R8 contents kept");
    chk("R8 empty", {31'h0, cmdAvail}, 0);
    chk("R8 sticky", {31'h0, cmdOverflow}, 1);

    // R5 short pulse on telemetry line, then an independently timed word
    telSel = 1'b0;
    base = telCount;
    repeat (3) begin telDrv = 1'b1; @(negedge clk); end
    telDrv = 1'b0;
    repeat (300) @(negedge clk);
    chk("R5 glitch ignored", telCount, base);
    expTel.push_back(24'h5AC3E1);
    bang_word(24'h5AC3E1);
    repeat (20) @(negedge clk);
    chk("R5 word after glitch", telCount, base + 1);
    chk("R4 all words seen", expTel.size(), 0);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule